// File: doc/BRIEF.md
# Reset-Synchronized Glitch Pulse Sequencer

This block times fault-injection attempts against an external target board. A byte-oriented command stream (one byte per cycle with a valid strobe) loads a 16-bit delay and a 16-bit pulse width. A fire command then runs one attempt. The block pulls the target's active-low reset low for a fixed number of cycles and releases it. It counts the programmed delay from that release and then drives a glitch pulse of the programmed width. All timing comes from counters on the block clock, so every attempt with the same settings has exactly the same cycle counts.

A sweep command runs a nested search. It starts from the loaded delay and width. On each attempt the width grows by one, until it reaches the width ceiling. The width then returns to its starting value and the delay grows by one. A fixed settle interval separates consecutive attempts. The sweep ends after the attempt that sits at both ceilings. An abort byte stops any activity at once. The current delay and width are always visible on the outputs.

Top module: `glitch_sequencer`

## Requirements
- R1: The byte 0x01 followed by two bytes, low byte first, loads the delay. The byte 0x02 followed by two bytes, low byte first, loads the width. After the second operand byte, cur_delay_o and cur_width_o show the loaded values.
- R2: The byte 0x03 starts one attempt. target_rst_no is low for exactly RST_CYCLES consecutive cycles and then goes high.
- R3: glitch_o first goes high exactly cur_delay_o cycles after the first cycle in which target_rst_no is high. A delay of 0 means the same cycle. glitch_o is never high while target_rst_no is low.
- R4: glitch_o stays high for exactly cur_width_o consecutive cycles.
- R5: With a width of 0, the reset sequence still runs in full and glitch_o never goes high.
- R6: busy_o is high from the first reset-low cycle through the last glitch cycle. In single-attempt mode it is low in the cycle after the pulse ends.
- R7: While busy_o is high, every byte other than 0x05 is ignored. The stored delay and width do not change, and no new attempt or sweep starts.
- R8: The byte 0x05, accepted while busy, gives glitch_o low, target_rst_no high and busy_o low in the next cycle.
- R9: The byte 0x04 starts a sweep from the loaded values. The width advances by one per attempt up to W_MAX. The delay then advances by one and the width returns to its start value.
- R10: During a sweep, the next reset assertion comes exactly SETTLE_CYCLES cycles after a glitch pulse ends. busy_o stays high across the whole sweep.
- R11: The sweep ends after the attempt in which the delay is at least DLY_MAX and the width is at least W_MAX. busy_o then clears. A sweep started at or above both ceilings runs exactly one attempt.
- R12: Opcode bytes other than 0x01 to 0x05 are ignored. A following byte is treated as a new opcode, not as an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; one cycle is one unit of delay and width |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_data_i | input | 8 | Command or operand byte |
| target_rst_no | output | 1 | Active-low reset to the target board |
| glitch_o | output | 1 | Glitch pulse, active high |
| busy_o | output | 1 | An attempt or sweep is in progress |
| cur_delay_o | output | 16 | Delay of the stored or current attempt |
| cur_width_o | output | 16 | Width of the stored or current attempt |

## Verification
The bench measures the reset length, the release-to-pulse delay and the pulse width in clock cycles. It covers delay 0, width 0 and width 1; an off-by-one counter compare shows up as a pulse one cycle late or one cycle too long. A sweep is checked attempt by attempt for the width-first order, the settle gap and the final stop. A design that swapped the loop order, skipped the last combination or dropped busy between attempts would log the wrong sequence or the wrong count. Configuration bytes sent during an attempt, and an abort both during reset and during the pulse, check that stored values survive and that the outputs return to idle in one cycle.

// File: rtl/glitch_seq_pkg.sv
package glitch_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_SET_DLY = 8'h01;
  localparam logic [BYTE_W-1:0] OP_SET_W   = 8'h02;
  localparam logic [BYTE_W-1:0] OP_FIRE    = 8'h03;
  localparam logic [BYTE_W-1:0] OP_SWEEP   = 8'h04;
  localparam logic [BYTE_W-1:0] OP_ABORT   = 8'h05;

  typedef enum logic [2:0] {
    P_OP, P_DLO, P_DHI, P_WLO, P_WHI
  } parse_state_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_DLY, ST_GLT, ST_SETTLE
  } seq_state_e;
endpackage

// File: rtl/glitch_cmd_rx.sv
module glitch_cmd_rx
  import glitch_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              busy_i,
  output logic              wr_dly_o,
  output logic              wr_w_o,
  output logic [VAL_W-1:0]  wr_val_o,
  output logic              fire_o,
  output logic              sweep_o,
  output logic              abort_o
);
  parse_state_e      pst_q, pst_d;
  logic [BYTE_W-1:0] lo_q;

  assign wr_val_o = {data_i, lo_q};

  always_comb begin
    wr_dly_o = 1'b0;
    wr_w_o   = 1'b0;
    fire_o   = 1'b0;
    sweep_o  = 1'b0;
    abort_o  = 1'b0;
    pst_d    = pst_q;
    if (valid_i) begin
      unique case (pst_q)
        P_OP: begin
          if (data_i == OP_ABORT) abort_o = 1'b1;
          else if (!busy_i) begin
            unique case (data_i)
              OP_SET_DLY: pst_d = P_DLO;
              OP_SET_W:   pst_d = P_WLO;
              OP_FIRE:    fire_o = 1'b1;
              OP_SWEEP:   sweep_o = 1'b1;
              default: ;
            endcase
          end
        end
        P_DLO: pst_d = P_DHI;
        P_DHI: begin
          wr_dly_o = 1'b1;
          pst_d    = P_OP;
        end
        P_WLO: pst_d = P_WHI;
        P_WHI: begin
          wr_w_o = 1'b1;
          pst_d  = P_OP;
        end
        default: pst_d = P_OP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pst_q <= P_OP;
      lo_q  <= '0;
    end else begin
      pst_q <= pst_d;
      if (valid_i && (pst_q == P_DLO || pst_q == P_WLO)) lo_q <= data_i;
    end
  end
endmodule

// File: rtl/glitch_param_regs.sv
module glitch_param_regs
  import glitch_seq_pkg::*;
#(
  parameter logic [VAL_W-1:0] W_MAX   = 16'd255,
  parameter logic [VAL_W-1:0] DLY_MAX = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_dly_i,
  input  logic             wr_w_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic             sweep_start_i,
  input  logic             step_i,
  output logic [VAL_W-1:0] dly_o,
  output logic [VAL_W-1:0] w_o,
  output logic             at_max_o
);
  logic [VAL_W-1:0] dly_q, w_q, w_min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= '0;
      w_q     <= '0;
      w_min_q <= '0;
    end else begin
      if (wr_dly_i) dly_q <= wr_val_i;
      if (wr_w_i)   w_q   <= wr_val_i;
      if (sweep_start_i) w_min_q <= w_q;
      if (step_i) begin
        // width is the inner loop
        if (w_q < W_MAX) begin
          w_q <= w_q + 1'b1;
        end else begin
          w_q   <= w_min_q;
          dly_q <= dly_q + 1'b1;
        end
      end
    end
  end

  assign dly_o    = dly_q;
  assign w_o      = w_q;
  assign at_max_o = (w_q >= W_MAX) && (dly_q >= DLY_MAX);
endmodule

// File: rtl/glitch_timer.sv
module glitch_timer
  import glitch_seq_pkg::*;
#(
  parameter int RST_CYCLES    = 1024,
  parameter int SETTLE_CYCLES = 65536
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             sweep_i,
  input  logic             abort_i,
  input  logic [VAL_W-1:0] dly_i,
  input  logic [VAL_W-1:0] w_i,
  input  logic             at_max_i,
  output logic             target_rst_no,
  output logic             glitch_o,
  output logic             busy_o,
  output logic             step_o
);
  localparam int LIM_A = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int LIM_B = (LIM_A > (1 << VAL_W)) ? LIM_A : (1 << VAL_W);
  localparam int TW    = $clog2(LIM_B) + 1;
  localparam logic [TW-1:0] RST_LAST    = TW'(RST_CYCLES - 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYCLES - 1);

  seq_state_e  st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic        sweep_q, sweep_d;
  logic        fin;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    sweep_d = sweep_q;
    step_o  = 1'b0;
    fin     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (fire_i || sweep_i) begin
          st_d    = ST_RST;
          sweep_d = sweep_i;
        end
      end
      ST_RST: begin
        if (cnt_q == RST_LAST) begin
          cnt_d = '0;
          if (dly_i != '0)    st_d = ST_DLY;
          else if (w_i != '0) st_d = ST_GLT;
          else                fin  = 1'b1;
        end
      end
      ST_DLY: begin
        if (cnt_q == TW'(dly_i) - TW'(1)) begin
          cnt_d = '0;
          if (w_i != '0) st_d = ST_GLT;
          else           fin  = 1'b1;
        end
      end
      ST_GLT: begin
        if (cnt_q == TW'(w_i) - TW'(1)) fin = 1'b1;
      end
      ST_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          cnt_d  = '0;
          step_o = 1'b1;
          st_d   = ST_RST;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) begin
      cnt_d = '0;
      if (sweep_q && !at_max_i) begin
        st_d = ST_SETTLE;
      end else begin
        st_d    = ST_IDLE;
        sweep_d = 1'b0;
      end
    end
    if (abort_i) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      sweep_d = 1'b0;
      step_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sweep_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sweep_q <= sweep_d;
    end
  end

  assign target_rst_no = (st_q != ST_RST);
  assign glitch_o      = (st_q == ST_GLT);
  assign busy_o        = (st_q != ST_IDLE);
endmodule

// File: rtl/glitch_sequencer.sv
module glitch_sequencer
  import glitch_seq_pkg::*;
#(
  parameter int RST_CYCLES    = 1024,
  parameter int SETTLE_CYCLES = 65536,
  parameter logic [15:0] W_MAX   = 16'd255,
  parameter logic [15:0] DLY_MAX = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [7:0]  cmd_data_i,
  output logic        target_rst_no,
  output logic        glitch_o,
  output logic        busy_o,
  output logic [15:0] cur_delay_o,
  output logic [15:0] cur_width_o
);
  logic             wr_dly, wr_w, fire, sweep, abort, step, at_max;
  logic [VAL_W-1:0] wr_val;

  glitch_cmd_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (cmd_valid_i),
    .data_i   (cmd_data_i),
    .busy_i   (busy_o),
    .wr_dly_o (wr_dly),
    .wr_w_o   (wr_w),
    .wr_val_o (wr_val),
    .fire_o   (fire),
    .sweep_o  (sweep),
    .abort_o  (abort)
  );

  glitch_param_regs #(
    .W_MAX   (W_MAX),
    .DLY_MAX (DLY_MAX)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_dly_i      (wr_dly),
    .wr_w_i        (wr_w),
    .wr_val_i      (wr_val),
    .sweep_start_i (sweep),
    .step_i        (step),
    .dly_o         (cur_delay_o),
    .w_o           (cur_width_o),
    .at_max_o      (at_max)
  );

  glitch_timer #(
    .RST_CYCLES    (RST_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_i        (fire),
    .sweep_i       (sweep),
    .abort_i       (abort),
    .dly_i         (cur_delay_o),
    .w_i           (cur_width_o),
    .at_max_i      (at_max),
    .target_rst_no (target_rst_no),
    .glitch_o      (glitch_o),
    .busy_o        (busy_o),
    .step_o        (step)
  );
endmodule

// File: rtl/glitch_sequencer_chk.sv
module glitch_sequencer_chk #(
  parameter int RST_CYCLES = 1024
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [7:0]  cmd_data_i,
  input logic        target_rst_no,
  input logic        glitch_o,
  input logic        busy_o,
  input logic [15:0] cur_width_o
);
  localparam int CW = $clog2(RST_CYCLES + 1) + 17;
  logic [CW-1:0] rst_run_q, glt_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_run_q <= '0;
      glt_run_q <= '0;
    end else begin
      rst_run_q <= target_rst_no ? '0 : rst_run_q + 1'b1;
      glt_run_q <= glitch_o ? glt_run_q + 1'b1 : '0;
    end
  end

  p_rst_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !target_rst_no |-> busy_o);
  p_glitch_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_o |-> busy_o);
  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glitch_o && !target_rst_no));
  p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_data_i == 8'h05 && busy_o) |=> (!busy_o && !glitch_o && target_rst_no));
  p_rst_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !target_rst_no |-> (rst_run_q < CW'(RST_CYCLES)));
  p_width_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_o |-> (glt_run_q < CW'(cur_width_o)));
endmodule

bind glitch_sequencer glitch_sequencer_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_data_i    (cmd_data_i),
  .target_rst_no (target_rst_no),
  .glitch_o      (glitch_o),
  .busy_o        (busy_o),
  .cur_width_o   (cur_width_o)
);

// File: tb/glitch_sequencer_bench.sv
module glitch_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC   = 16;
  localparam int SETTLE = 40;
  localparam int WMAX   = 3;
  localparam int DMAX   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic        trst_n, glitch, busy;
  logic [15:0] cur_d, cur_w;

  int n_chk = 0;
  int n_fail = 0;

  glitch_sequencer #(
    .RST_CYCLES(RSTC), .SETTLE_CYCLES(SETTLE),
    .W_MAX(16'(WMAX)), .DLY_MAX(16'(DMAX))
  ) u_glitch_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_data_i(data),
    .target_rst_no(trst_n), .glitch_o(glitch), .busy_o(busy),
    .cur_delay_o(cur_d), .cur_width_o(cur_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // cycle monitor
  int cyc = 0;
  int n_rel = 0, n_glit = 0, n_bfall = 0, bad_busy = 0;
  int rst_fall_t = 0, rst_len = 0, rel_t = 0, gs_t = 0, g_end_t = 0, gap = -1;
  int busy_at_gfall = 0;
  int dly_log[16], w_log[16], cd_log[16], cw_log[16];
  logic prev_rst = 1'b1, prev_g = 1'b0, prev_b = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if ((!trst_n || glitch) && !busy) bad_busy++;
    if (!trst_n && prev_rst) begin
      rst_fall_t = cyc;
      if (n_glit > 0) gap = cyc - g_end_t;
    end
    if (trst_n && !prev_rst) begin
      rst_len = cyc - rst_fall_t;
      rel_t = cyc;
      n_rel++;
    end
    if (glitch && !prev_g) begin
      gs_t = cyc;
      dly_log[n_glit & 15] = cyc - rel_t;
      cd_log[n_glit & 15] = int'(cur_d);
      cw_log[n_glit & 15] = int'(cur_w);
    end
    if (!glitch && prev_g) begin
      w_log[n_glit & 15] = cyc - gs_t;
      g_end_t = cyc;
      busy_at_gfall = int'(busy);
      n_glit++;
    end
    if (!busy && prev_b) n_bfall++;
    prev_rst = trst_n;
    prev_g = glitch;
    prev_b = busy;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    valid = 1'b1;
    data = b;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic load(int d, int w);
    send_byte(8'h01); send_byte(8'(d)); send_byte(8'(d >> 8));
    send_byte(8'h02); send_byte(8'(w)); send_byte(8'(w >> 8));
  endtask

  task automatic wait_idle(int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
    chk("R6 idle reached", int'(busy), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset release at rest", int'(trst_n), 1);
    chk("R3 no glitch at rest", int'(glitch), 0);
    chk("R6 busy low at rest", int'(busy), 0);
    chk("R1 delay at reset", int'(cur_d), 0);
  endtask

  task automatic t_config();
    load(16'h1234, 16'hABCD);
    chk("R1 delay load", int'(cur_d), 16'h1234);
    chk("R1 width load", int'(cur_w), 16'hABCD);
  endtask

  task automatic t_unknown();
    load(7, 3);
    send_byte(8'h07); send_byte(8'h03);
    wait_idle(200);
    chk("R12 fire after unknown runs", n_rel > 0 ? 1 : 0, 1);
    send_byte(8'h00); send_byte(8'h09); send_byte(8'h55);
    chk("R12 delay kept", int'(cur_d), 7);
    chk("R12 width kept", int'(cur_w), 3);
    chk("R12 stays idle", int'(busy), 0);
  endtask

  task automatic t_single(int d, int w);
    int g0 = n_glit;
    load(d, w);
    send_byte(8'h03);
    wait_idle(2000);
    chk("R2 reset low length", rst_len, RSTC);
    chk("R4 one pulse", n_glit - g0, 1);
    chk("R3 release to pulse", dly_log[g0 & 15], d);
    chk("R4 pulse width", w_log[g0 & 15], w);
    chk("R6 busy low after pulse", busy_at_gfall, 0);
    chk("R6 busy covers activity", bad_busy, 0);
  endtask

  task automatic t_zero_w();
    int g0 = n_glit;
    int r0 = n_rel;
    load(2, 0);
    send_byte(8'h03);
    wait_idle(2000);
    chk("R5 reset still runs", n_rel - r0, 1);
    chk("R5 reset length", rst_len, RSTC);
    chk("R5 no pulse", n_glit - g0, 0);
  endtask

  task automatic t_busy_ignore();
    int r0;
    load(4, 2);
    r0 = n_rel;
    send_byte(8'h03);
    send_byte(8'h01); send_byte(8'hAA); send_byte(8'hBB);
    send_byte(8'h02); send_byte(8'h11);
    send_byte(8'h04); send_byte(8'h03);
    wait_idle(2000);
    chk("R7 delay unchanged", int'(cur_d), 4);
    chk("R7 width unchanged", int'(cur_w), 2);
    chk("R7 single attempt", n_rel - r0, 1);
    repeat (SETTLE + RSTC) @(negedge clk);
    chk("R7 no sweep started", int'(busy), 0);
  endtask

  task automatic t_abort();
    load(2, 200);
    send_byte(8'h03);
    for (int i = 0; i < 500 && !glitch; i++) @(negedge clk);
    chk("R8 pulse reached", int'(glitch), 1);
    send_byte(8'h05);
    chk("R8 glitch low", int'(glitch), 0);
    chk("R8 reset released", int'(trst_n), 1);
    chk("R8 busy low", int'(busy), 0);
    send_byte(8'h03);
    repeat (3) @(negedge clk);
    chk("R8 in reset before abort", int'(trst_n), 0);
    send_byte(8'h05);
    chk("R8 reset released in reset phase", int'(trst_n), 1);
    chk("R8 busy low in reset phase", int'(busy), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_sweep();
    int g0, b0;
    int ed[4] = '{5, 5, 6, 6};
    int ew[4] = '{2, 3, 2, 3};
    load(5, 2);
    g0 = n_glit;
    b0 = n_bfall;
    send_byte(8'h04);
    wait_idle(5000);
    chk("R11 attempt count", n_glit - g0, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R9 sweep delay value", cd_log[(g0 + k) & 15], ed[k]);
      chk("R9 sweep width value", cw_log[(g0 + k) & 15], ew[k]);
      chk("R9 measured delay", dly_log[(g0 + k) & 15], ed[k]);
      chk("R9 measured width", w_log[(g0 + k) & 15], ew[k]);
    end
    chk("R10 settle gap", gap, SETTLE);
    chk("R10 busy held across sweep", n_bfall - b0, 1);
    chk("R11 final delay", int'(cur_d), DMAX);
    chk("R11 final width", int'(cur_w), WMAX);
    load(9, 5);
    g0 = n_glit;
    send_byte(8'h04);
    wait_idle(2000);
    chk("R11 start above ceilings runs once", n_glit - g0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_config();
    t_unknown();
    t_single(3, 2);
    t_single(0, 1);
    t_single(3, 2);
    t_zero_w();
    t_busy_ignore();
    t_abort();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule